// File: doc/BRIEF.md
# Direct Digital Sine Synthesizer

This block produces a continuous digital sine wave whose frequency is set at run time. A 10-bit phase accumulator adds a tuning word to itself on every clock and wraps modulo 1024. The seven most significant accumulator bits address a 128-entry table that covers one whole sine period as signed 8-bit samples. The table read is registered, so each sample appears one clock after its address.

The output frequency is fclk × tuning word / 1024. A tuning word of 1 walks the table once every 1024 clocks. Larger words step through the table faster. A word of 0 freezes the phase, so the output stays at one constant sample. The three low accumulator bits give fractional phase: they change when the next table entry is reached, but never the sample itself.

The sine values are built inside the design from a 33-value quarter-wave description that is mirrored and negated, so no external file is needed. A synchronous, active-high reset clears both the accumulator and the output register.

Top module: `dds_sine_top`

## Requirements
- R1: While `rst` is high at a rising edge, `phase_o` and `sample_o` both become 0 at that edge; `freq_word_i` has no effect during reset.
- R2: At each rising edge out of reset, `phase_o` becomes (`phase_o` + `freq_word_i`) mod 1024, with no overflow indication.
- R3: The table address is `phase_o[9:3]`; bits [2:0] never affect `sample_o`.
- R4: `sample_o` after an edge equals the table entry addressed by `phase_o` before that edge (one clock of latency).
- R5: Table entry k is trunc(127·sin(2πk/128)) in two's complement: entry 0 = 0, entry 1 = 6, entries 30 and 31 = 126, entry 32 = +127, entry 64 = 0, entry 96 = −127 (0x81).
- R6: For k in 0..63, entry k+64 equals the negation of entry k (for example entry 65 = −6).
- R7: With `freq_word_i` = 0, `phase_o` holds its value, and from the second edge onward `sample_o` holds its value.
- R8: When `freq_word_i` divides 1024, `phase_o` and `sample_o` repeat with a period of exactly 1024 / `freq_word_i` clocks.
- R9: `freq_word_i` is sampled on every edge, so a new word takes effect at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| freq_word_i | input | 10 | Tuning word added to the phase each clock |
| phase_o | output | 10 | Current phase accumulator value |
| sample_o | output | 8 | Registered signed sine sample |

## Verification
The assertions assume that `rst` and `freq_word_i` are known (never X) from the first clock edge and change only between edges. They also assume that `rst` is asserted at time zero, so the registers start from a defined value. The bench holds reset from time zero and drives every input on the falling edge. It then compares each output on the next falling edge with a floating-point sine model and its own accumulator.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // Sine table geometry: 128 entries of 8-bit two's complement
    localparam int LUT_AW   = 7;
    localparam int SAMP_W   = 8;
    localparam int QTR_LAST = 1 << (LUT_AW - 2);   // index of the positive peak (32)

    typedef logic [LUT_AW-1:0]        lut_addr_t;
    typedef logic signed [SAMP_W-1:0] sample_t;

    // Magnitude of trunc(127*sin(2*pi*j/128)) for j = 0 .. 32
    function automatic logic [SAMP_W-2:0] quarter_mag(input int j);
        logic [SAMP_W-2:0] m;
        unique case (j)
            0:  m = 7'd0;    1:  m = 7'd6;    2:  m = 7'd12;   3:  m = 7'd18;
            4:  m = 7'd24;   5:  m = 7'd30;   6:  m = 7'd36;   7:  m = 7'd42;
            8:  m = 7'd48;   9:  m = 7'd54;   10: m = 7'd59;   11: m = 7'd65;
            12: m = 7'd70;   13: m = 7'd75;   14: m = 7'd80;   15: m = 7'd85;
            16: m = 7'd89;   17: m = 7'd94;   18: m = 7'd98;   19: m = 7'd102;
            20: m = 7'd105;  21: m = 7'd108;  22: m = 7'd112;  23: m = 7'd114;
            24: m = 7'd117;  25: m = 7'd119;  26: m = 7'd121;  27: m = 7'd123;
            28: m = 7'd124;  29: m = 7'd125;  30: m = 7'd126;  31: m = 7'd126;
            32: m = 7'd127;
            default: m = 7'd0;
        endcase
        return m;
    endfunction

    // Full-period sample: mirror inside each half, negate the second half
    function automatic sample_t sine_at(input lut_addr_t a);
        int                off;
        int                j;
        logic [SAMP_W-2:0] mag;
        sample_t           pos;
        off = int'(a[LUT_AW-2:0]);
        j   = (off <= QTR_LAST) ? off : (2 * QTR_LAST - off);
        mag = quarter_mag(j);
        pos = sample_t'({1'b0, mag});
        return a[LUT_AW-1] ? -pos : pos;
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] step_i,
    output logic [W-1:0] phase_o
);

    logic [W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_q + step_i;
    end

    assign phase_o = acc_q;

    // R2
    acc_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i[0] == 1'b0) |=> (acc_q[0] == $past(acc_q[0])))
        else $error("phase LSB moved under an even step");

    // R7
    freeze_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i == '0) |=> $stable(acc_q))
        else $error("phase moved with zero step");

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut
    import dds_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lut_addr_t addr_i,
    output sample_t   sample_o
);

    sample_t lut_val;
    sample_t sample_q;

    always_comb lut_val = sine_at(addr_i);

    always_ff @(posedge clk) begin
        if (rst) sample_q <= '0;
        else     sample_q <= lut_val;
    end

    assign sample_o = sample_q;

    // R5
    peak_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_i == lut_addr_t'(32)) |=> (sample_q == sample_t'(127)))
        else $error("positive peak wrong");

    // R5
    peak_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_i == lut_addr_t'(96)) |=> (sample_q == sample_t'(-127)))
        else $error("negative peak wrong");

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(addr_i) |=> $stable(sample_q))
        else $error("sample moved with a steady address");

endmodule

// File: rtl/dds_sine_top.sv
module dds_sine_top
    import dds_pkg::*;
#(
    parameter int PHASE_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] freq_word_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic [SAMP_W-1:0]  sample_o
);

    localparam int DROP_W = PHASE_W - LUT_AW;

    logic [PHASE_W-1:0] phase_w;
    lut_addr_t          lut_addr;
    sample_t            sample_w;

    dds_phase_acc #(.W(PHASE_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .step_i  (freq_word_i),
        .phase_o (phase_w)
    );

    // Only the upper bits address the table; the DROP_W low bits are fractional
    assign lut_addr = phase_w[PHASE_W-1 -: LUT_AW];

    dds_sine_lut u_lut (
        .clk      (clk),
        .rst      (rst),
        .addr_i   (lut_addr),
        .sample_o (sample_w)
    );

    assign phase_o  = phase_w;
    assign sample_o = sample_w;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (phase_o == '0 && sample_o == '0))
        else $error("reset did not clear outputs (drop %0d)", DROP_W);

endmodule

// File: tb/dds_sine_top_bench.sv
`timescale 1ns/1ps
module dds_sine_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] tw  = '0;
    logic [9:0] phase;
    logic [7:0] samp;

    int n_chk  = 0;
    int n_fail = 0;
    int tbl [128];
    int m_acc  = 0;
    int m_samp = 0;
    int hist [128];

    always #2 clk = ~clk;

    dds_sine_top u_dds_sine_top (
        .clk         (clk),
        .rst         (rst),
        .freq_word_i (tw),
        .phase_o     (phase),
        .sample_o    (samp)
    );

    localparam int NVEC = 8;
    localparam int VEC_TW  [NVEC] = '{1, 3, 8, 64, 128, 1023, 512, 77};
    localparam int VEC_CYC [NVEC] = '{1030, 400, 140, 40, 20, 40, 10, 60};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: update the model at the edge, return at the falling edge
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_acc  = 0;
            m_samp = 0;
        end else begin
            m_samp = tbl[m_acc >> 3];
            m_acc  = (m_acc + int'(tw)) % 1024;
        end
        @(negedge clk);
    endtask

    function automatic int s_out();
        return int'($signed(samp));
    endfunction

    task automatic check_model(input string req);
        chk(int'(phase) == m_acc, {req, " phase"}, int'(phase), m_acc);
        chk(s_out() == m_samp, {req, " sample"}, s_out(), m_samp);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 128; k++)
            tbl[k] = $rtoi(127.0 * $sin(2.0 * 3.14159265358979 * k / 128.0));

        // R1: reset state, tuning word ignored during reset
        tw = 10'd5;
        repeat (3) tick();
        chk(phase == 10'd0, "R1 phase", int'(phase), 0);
        chk(samp == 8'd0, "R1 sample", s_out(), 0);

        // R2 R4: vector table walked by one loop
        rst = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            tw = 10'(VEC_TW[v]);
            for (int c = 0; c < VEC_CYC[v]; c++) begin
                tick();
                check_model("R2 R4");
            end
        end

        // R8: exact period for divisors of 1024
        for (int v = 0; v < 3; v++) begin
            int p0, s0, per;
            bit early;
            tw  = (v == 0) ? 10'd8 : (v == 1) ? 10'd32 : 10'd128;
            tick();
            tick();
            per   = 1024 / int'(tw);
            p0    = int'(phase);
            s0    = s_out();
            early = 1'b0;
            for (int c = 1; c < per; c++) begin
                tick();
                if (int'(phase) == p0) early = 1'b1;
            end
            tick();
            chk(!early, "R8 no early repeat", int'(early), 0);
            chk(int'(phase) == p0, "R8 phase period", int'(phase), p0);
            chk(s_out() == s0, "R8 sample period", s_out(), s0);
        end

        // R5: peaks and zero crossings with step 256
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tw  = 10'd256;
        tick();
        chk(s_out() == 0, "R5 entry 0", s_out(), 0);
        tick();
        chk(s_out() == 127, "R5 entry 32", s_out(), 127);
        tick();
        chk(s_out() == 0, "R5 entry 64", s_out(), 0);
        tick();
        chk(s_out() == -127, "R5 entry 96", s_out(), -127);
        chk(samp == 8'h81, "R5 code 0x81", int'(samp), 129);

        // R6: collect one sample per entry with step 8
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tw  = 10'd8;
        for (int k = 0; k < 128; k++) begin
            tick();
            hist[k] = s_out();
        end
        chk(hist[1] == 6, "R5 entry 1", hist[1], 6);
        chk(hist[30] == 126, "R5 entry 30", hist[30], 126);
        chk(hist[31] == 126, "R5 entry 31", hist[31], 126);
        chk(hist[65] == -6, "R6 entry 65", hist[65], -6);
        for (int k = 0; k < 64; k++)
            chk(hist[k + 64] == -hist[k], "R6 odd half", hist[k + 64], -hist[k]);

        // R3: low three phase bits do not move the sample
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tw  = 10'd1;
        for (int k = 1; k <= 9; k++) begin
            tick();
            chk(s_out() == ((k == 9) ? 6 : 0), "R3 low bits", s_out(), (k == 9) ? 6 : 0);
        end

        // R7: zero tuning word freezes phase and sample
        tw = 10'd0;
        tick();
        begin
            int p0, s0;
            tick();
            p0 = int'(phase);
            s0 = s_out();
            for (int k = 0; k < 6; k++) begin
                tick();
                chk(int'(phase) == p0, "R7 phase hold", int'(phase), p0);
                chk(s_out() == s0, "R7 sample hold", s_out(), s0);
            end
        end

        // R9: a new word every clock takes effect at the next edge
        tw = 10'd5;    tick(); check_model("R9");
        tw = 10'd700;  tick(); check_model("R9");
        tw = 10'd1023; tick(); check_model("R9");
        tw = 10'd0;    tick(); check_model("R9");
        tw = 10'd2;    tick(); check_model("R9");

        // R1: reset in the middle of a run
        tw  = 10'd99;
        repeat (5) tick();
        rst = 1'b1;
        tick();
        chk(phase == 10'd0, "R1 mid-run phase", int'(phase), 0);
        chk(samp == 8'd0, "R1 mid-run sample", s_out(), 0);
        rst = 1'b0;
        tick();
        check_model("R1 release");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule